// File: doc/BRIEF.md
# Inbound DMA Address Window Translator

This block turns the 64-bit address of an inbound DMA request, as seen on the PCIe side, into a system address. It sorts the address into one of five windows. Two windows are direct: the 64-bit direct window passes the low address bits through, and the 32-bit direct window joins the low bits to a per-port upper-address register. Three windows go through translation tables: a 32-bit mapped window with a programmable page size, a 40-bit mapped window with 64 MB pages, and a 40-bit super-page window with 16 GB pages. Where a window defines a barrier attribute, that bit is stripped from the address and reported on its own output.

The block holds two tables. A shared table serves the super-page window in its low entries, split into one 32-entry partition per port, and the 32-bit mapped window above them. A separate table serves the 40-bit mapped window. It also holds the per-port direct-map registers and a page-shift register. All of this state is loaded through one configuration write port. A request presents the address and the port number with a strobe. One clock later the block returns the system address and the barrier flag, with either a valid flag or an error flag.

Top module: `dwx_xlate`

## Requirements
- R1: After reset the outputs are low, every table entry is invalid, every direct-map register is zero and the page shift is 18 (256 KB), so any table or 32-bit direct lookup made before configuration reports an error.
- R2: A request's result appears on the clock edge after the strobe, with exactly one of out_vld_o or out_err_o high. Both stay low in cycles without a request. Address and barrier change only on request cycles, and both are zero after an error.
- R3: An address with bit 63 set is 64-bit direct: the system address is bits 53:0 zero-extended, and bit 62 is the barrier flag.
- R4: A 64-bit direct address with bit 61 (message marker) or any of bits 60:54 set is reported as an error. With STRICT_D64=0, only bit 61 causes the error.
- R5: An address from 0x8000_0000 to 0xFFFF_FFFF is 32-bit direct: the system address is {port register bits 63:30, address bits 29:0}, and address bit 30 is the barrier flag.
- R6: A 32-bit direct request whose port register is zero is an error.
- R7: An address from 0x0 to 0x7FFF_FFFF is 32-bit mapped. Bit 30 is the barrier flag, the offset is bits 29:0, the index is offset >> page shift, and the shared-table entry used is NUM_PORTS*32 + index.
- R8: An address from 0x40_0000_0000 to 0x7F_FFFF_FFFF uses the 40-bit table at index (address - 0x40_0000_0000) >> 26, with a 64 MB page. Its barrier is always 0.
- R9: An address from 0x80_0000_0000 to 0xFF_FFFF_FFFF uses shared entry port*32 + ((address - 0x80_0000_0000) >> 34), with a 16 GB page. Its barrier is always 0.
- R10: A table entry is valid when bit 63 is set. The system address is the entry's bits 62:0 with the in-page bits cleared, OR the in-page offset of the address. A hit on an invalid entry is an error.
- R11: An address outside all five windows, or a table index at or beyond the depth of its table or partition, is an error.
- R12: A configuration write targets by cfg_tgt_i: 0 = shared entry cfg_idx_i, 1 = 40-bit entry cfg_idx_i, 2 = direct-map register of port cfg_idx_i (takes cfg_data_i[63:30]), 3 = page shift (takes cfg_data_i[5:0], and is ignored outside 12..30). A request in the same cycle as a write sees the old contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Translation request strobe |
| req_port_i | input | PORT_W | Port the request arrived on |
| req_addr_i | input | 64 | Inbound bus address |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_tgt_i | input | 2 | Write target (see R12) |
| cfg_idx_i | input | CFG_IDX_W | Entry or port index for the write |
| cfg_data_i | input | 64 | Write data |
| out_vld_o | output | 1 | Translation succeeded |
| out_err_o | output | 1 | Translation failed |
| out_barrier_o | output | 1 | Barrier attribute of the request |
| out_addr_o | output | 64 | Translated system address |

## Verification
The bench targets the edges of each window. These include 0x7FFF_FFFF against 0x8000_0000, the gap between 4 GB and 256 GB, and the first address past 1 TB. A design that put a window boundary one bit off would return a translation where an error belongs, or the reverse. The bench moves the page shift away from its reset value, and also writes an out-of-range shift that must be ignored. A design with a fixed page size would then pick the wrong entry and merge the wrong offset bits. Super-page lookups from both ports hit entries that differ only in partition, and a missing partition offset returns the other port's page. The bench also issues a request in the same cycle as a write to the entry it reads, which catches a design that forwards the new data. Lookups of invalid entries, reserved 64-bit bits set, and an unloaded direct-map register must all produce errors rather than silent translations.

// File: rtl/dwx_pkg.sv
`timescale 1ns/1ps
package dwx_pkg;
   // window that an inbound address falls into
   typedef enum logic [2:0] {
      WIN_NONE = 3'd0,
      WIN_D64  = 3'd1,
      WIN_D32  = 3'd2,
      WIN_M32  = 3'd3,
      WIN_M40  = 3'd4,
      WIN_M40S = 3'd5
   } win_e;

   // configuration write targets
   typedef enum logic [1:0] {
      CFG_SHARED = 2'd0,
      CFG_M40    = 2'd1,
      CFG_DIRMAP = 2'd2,
      CFG_PGSH   = 2'd3
   } cfg_tgt_e;

   localparam int SP_PER_PORT = 32;  // super-page entries per port
   localparam int SP_SHIFT    = 34;  // 16 GB pages
   localparam int M40_SHIFT   = 26;  // 64 MB pages
   localparam int DIR_W       = 34;  // direct-map register holds bits 63:30
endpackage

// File: rtl/dwx_classify.sv
`timescale 1ns/1ps
module dwx_classify
   import dwx_pkg::*;
#(
   parameter int NUM_PORTS   = 2,
   parameter int M32_ENTRIES = 64,
   parameter int M40_ENTRIES = 64,
   parameter int PORT_W      = 1,
   parameter int SHR_W       = 7,
   parameter int M40_W       = 6,
   parameter bit STRICT_D64  = 1'b1
) (
   input  logic [63:0]       addr_i,
   input  logic [PORT_W-1:0] port_i,
   input  logic [5:0]        pgsh_i,
   output win_e              win_o,
   output logic              barrier_o,
   output logic              rsv_err_o,
   output logic [SHR_W-1:0]  shr_idx_o,
   output logic              shr_ok_o,
   output logic [M40_W-1:0]  m40_idx_o,
   output logic              m40_ok_o,
   output logic [63:0]       mask_o
);
   localparam int SP_TOTAL = NUM_PORTS * SP_PER_PORT;

   logic [29:0] m32_raw;
   logic [11:0] m40_raw;
   logic [4:0]  sp_raw;
   logic        port_ok;

   assign m32_raw = addr_i[29:0] >> pgsh_i;
   assign m40_raw = addr_i[37:26];
   assign sp_raw  = addr_i[38:34];
   assign port_ok = ({1'b0, port_i} < (PORT_W+1)'(NUM_PORTS));

   // window decode, highest window first
   always_comb begin
      if (addr_i[63])
         win_o = WIN_D64;
      else if (addr_i[62:32] == '0 && addr_i[31])
         win_o = WIN_D32;
      else if (addr_i[62:31] == '0)
         win_o = WIN_M32;
      else if (addr_i[62:40] == '0 && addr_i[39:38] == 2'b01)
         win_o = WIN_M40;
      else if (addr_i[62:40] == '0 && addr_i[39])
         win_o = WIN_M40S;
      else
         win_o = WIN_NONE;
   end

   // reserved-bit policy of the 64-bit direct window
   generate
      if (STRICT_D64) begin : g_rsv_strict
         assign rsv_err_o = (win_o == WIN_D64) && (addr_i[61:54] != '0);
      end else begin : g_rsv_loose
         assign rsv_err_o = (win_o == WIN_D64) && addr_i[61];
      end
   endgenerate

   always_comb begin
      barrier_o = 1'b0;
      shr_idx_o = '0;
      shr_ok_o  = 1'b0;
      m40_idx_o = '0;
      m40_ok_o  = 1'b0;
      mask_o    = '0;
      case (win_o)
         WIN_D64: barrier_o = addr_i[62];
         WIN_D32: barrier_o = addr_i[30];
         WIN_M32: begin
            barrier_o = addr_i[30];
            mask_o    = (64'd1 << pgsh_i) - 64'd1;
            shr_ok_o  = ({2'b0, m32_raw} < 32'(M32_ENTRIES));
            if (shr_ok_o)
               shr_idx_o = SHR_W'(SP_TOTAL) + SHR_W'(m32_raw);
         end
         WIN_M40: begin
            mask_o   = (64'd1 << M40_SHIFT) - 64'd1;
            m40_ok_o = ({20'b0, m40_raw} < 32'(M40_ENTRIES));
            if (m40_ok_o)
               m40_idx_o = M40_W'(m40_raw);
         end
         WIN_M40S: begin
            mask_o   = (64'd1 << SP_SHIFT) - 64'd1;
            shr_ok_o = port_ok;
            if (port_ok)
               shr_idx_o = SHR_W'(port_i) * SHR_W'(SP_PER_PORT) + SHR_W'(sp_raw);
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/dwx_tables.sv
`timescale 1ns/1ps
module dwx_tables
   import dwx_pkg::*;
#(
   parameter int NUM_PORTS   = 2,
   parameter int SHR_DEPTH   = 128,
   parameter int M40_ENTRIES = 64,
   parameter int PORT_W      = 1,
   parameter int SHR_W       = 7,
   parameter int M40_W       = 6,
   parameter int CFG_IDX_W   = 7,
   parameter int PGSH_RST    = 18,
   parameter int PGSH_MIN    = 12,
   parameter int PGSH_MAX    = 30
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we_i,
   input  cfg_tgt_e             cfg_tgt_i,
   input  logic [CFG_IDX_W-1:0] cfg_idx_i,
   input  logic [63:0]          cfg_data_i,
   input  logic [SHR_W-1:0]     rd_shr_idx_i,
   input  logic [M40_W-1:0]     rd_m40_idx_i,
   input  logic [PORT_W-1:0]    rd_port_i,
   output logic [63:0]          shr_ent_o,
   output logic [63:0]          m40_ent_o,
   output logic [DIR_W-1:0]     dir_hi_o,
   output logic [5:0]           pgsh_o
);
   logic [63:0]      shr_q [SHR_DEPTH];
   logic [63:0]      m40_q [M40_ENTRIES];
   logic [DIR_W-1:0] dir_q [NUM_PORTS];
   logic [5:0]       pgsh_q;

   logic wr_shr, wr_m40, wr_dir, wr_pgsh;

   assign wr_shr  = cfg_we_i && cfg_tgt_i == CFG_SHARED &&
                    ({1'b0, cfg_idx_i} < (CFG_IDX_W+1)'(SHR_DEPTH));
   assign wr_m40  = cfg_we_i && cfg_tgt_i == CFG_M40 &&
                    ({1'b0, cfg_idx_i} < (CFG_IDX_W+1)'(M40_ENTRIES));
   assign wr_dir  = cfg_we_i && cfg_tgt_i == CFG_DIRMAP;
   assign wr_pgsh = cfg_we_i && cfg_tgt_i == CFG_PGSH &&
                    cfg_data_i[5:0] >= 6'(PGSH_MIN) && cfg_data_i[5:0] <= 6'(PGSH_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SHR_DEPTH; i++) shr_q[i] <= '0;
      end else if (wr_shr) begin
         shr_q[cfg_idx_i[SHR_W-1:0]] <= cfg_data_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < M40_ENTRIES; i++) m40_q[i] <= '0;
      end else if (wr_m40) begin
         m40_q[cfg_idx_i[M40_W-1:0]] <= cfg_data_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int p = 0; p < NUM_PORTS; p++) dir_q[p] <= '0;
      end else if (wr_dir) begin
         for (int p = 0; p < NUM_PORTS; p++)
            if (cfg_idx_i == CFG_IDX_W'(p)) dir_q[p] <= cfg_data_i[63:30];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pgsh_q <= 6'(PGSH_RST);
      else if (wr_pgsh) pgsh_q <= cfg_data_i[5:0];
   end

   assign shr_ent_o = shr_q[rd_shr_idx_i];
   assign m40_ent_o = m40_q[rd_m40_idx_i];
   assign pgsh_o    = pgsh_q;

   always_comb begin
      dir_hi_o = '0;
      for (int p = 0; p < NUM_PORTS; p++)
         if (rd_port_i == PORT_W'(p)) dir_hi_o = dir_q[p];
   end
endmodule

// File: rtl/dwx_xlate.sv
`timescale 1ns/1ps
module dwx_xlate
   import dwx_pkg::*;
#(
   parameter int NUM_PORTS   = 2,
   parameter int M32_ENTRIES = 64,
   parameter int M40_ENTRIES = 64,
   parameter int PGSH_RST    = 18,
   parameter int PGSH_MIN    = 12,
   parameter int PGSH_MAX    = 30,
   parameter bit STRICT_D64  = 1'b1,
   localparam int PORT_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
   localparam int SHR_DEPTH  = NUM_PORTS * SP_PER_PORT + M32_ENTRIES,
   localparam int SHR_W      = $clog2(SHR_DEPTH),
   localparam int M40_W      = (M40_ENTRIES > 1) ? $clog2(M40_ENTRIES) : 1,
   localparam int CFG_IDX_W  = (SHR_W > M40_W) ? SHR_W : M40_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_i,
   input  logic [PORT_W-1:0]    req_port_i,
   input  logic [63:0]          req_addr_i,
   input  logic                 cfg_we_i,
   input  logic [1:0]           cfg_tgt_i,
   input  logic [CFG_IDX_W-1:0] cfg_idx_i,
   input  logic [63:0]          cfg_data_i,
   output logic                 out_vld_o,
   output logic                 out_err_o,
   output logic                 out_barrier_o,
   output logic [63:0]          out_addr_o
);
   // elaboration-time parameter checks
   generate
      if (NUM_PORTS < 1) begin : g_bad_ports
         $error("dwx_xlate: NUM_PORTS must be at least 1");
      end
      if (M32_ENTRIES < 1 || M40_ENTRIES < 1 || M40_ENTRIES > 4096) begin : g_bad_depth
         $error("dwx_xlate: table depth out of range");
      end
      if (PGSH_MIN > PGSH_RST || PGSH_RST > PGSH_MAX || PGSH_MAX > 30) begin : g_bad_pgsh
         $error("dwx_xlate: page shift limits inconsistent");
      end
   endgenerate

   win_e             win;
   logic             bar;
   logic             rsv_err;
   logic [SHR_W-1:0] shr_idx;
   logic             shr_ok;
   logic [M40_W-1:0] m40_idx;
   logic             m40_ok;
   logic [63:0]      mask;
   logic [63:0]      shr_ent;
   logic [63:0]      m40_ent;
   logic [DIR_W-1:0] dir_hi;
   logic [5:0]       pgsh;

   dwx_classify #(
      .NUM_PORTS  (NUM_PORTS),
      .M32_ENTRIES(M32_ENTRIES),
      .M40_ENTRIES(M40_ENTRIES),
      .PORT_W     (PORT_W),
      .SHR_W      (SHR_W),
      .M40_W      (M40_W),
      .STRICT_D64 (STRICT_D64)
   ) u_cls (
      .addr_i   (req_addr_i),
      .port_i   (req_port_i),
      .pgsh_i   (pgsh),
      .win_o    (win),
      .barrier_o(bar),
      .rsv_err_o(rsv_err),
      .shr_idx_o(shr_idx),
      .shr_ok_o (shr_ok),
      .m40_idx_o(m40_idx),
      .m40_ok_o (m40_ok),
      .mask_o   (mask)
   );

   dwx_tables #(
      .NUM_PORTS  (NUM_PORTS),
      .SHR_DEPTH  (SHR_DEPTH),
      .M40_ENTRIES(M40_ENTRIES),
      .PORT_W     (PORT_W),
      .SHR_W      (SHR_W),
      .M40_W      (M40_W),
      .CFG_IDX_W  (CFG_IDX_W),
      .PGSH_RST   (PGSH_RST),
      .PGSH_MIN   (PGSH_MIN),
      .PGSH_MAX   (PGSH_MAX)
   ) u_tbl (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_we_i    (cfg_we_i),
      .cfg_tgt_i   (cfg_tgt_e'(cfg_tgt_i)),
      .cfg_idx_i   (cfg_idx_i),
      .cfg_data_i  (cfg_data_i),
      .rd_shr_idx_i(shr_idx),
      .rd_m40_idx_i(m40_idx),
      .rd_port_i   (req_port_i),
      .shr_ent_o   (shr_ent),
      .m40_ent_o   (m40_ent),
      .dir_hi_o    (dir_hi),
      .pgsh_o      (pgsh)
   );

   logic        x_err;
   logic [63:0] x_addr;
   logic        x_bar;
   logic [63:0] ent;
   logic        ent_ok;

   // pick the table entry the window reads
   always_comb begin
      ent    = (win == WIN_M40) ? m40_ent : shr_ent;
      ent_ok = (win == WIN_M40) ? m40_ok  : shr_ok;
   end

   always_comb begin
      x_err  = 1'b0;
      x_addr = '0;
      case (win)
         WIN_D64: begin
            x_err  = rsv_err;
            x_addr = {10'b0, req_addr_i[53:0]};
         end
         WIN_D32: begin
            x_err  = (dir_hi == '0);
            x_addr = {dir_hi, req_addr_i[29:0]};
         end
         WIN_M32, WIN_M40, WIN_M40S: begin
            x_err  = !ent_ok || !ent[63];
            x_addr = ({1'b0, ent[62:0]} & ~mask) | (req_addr_i & mask);
         end
         default: x_err = 1'b1;
      endcase
      x_bar = bar && !x_err;
      if (x_err) x_addr = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld_o     <= 1'b0;
         out_err_o     <= 1'b0;
         out_barrier_o <= 1'b0;
         out_addr_o    <= '0;
      end else begin
         out_vld_o <= req_i && !x_err;
         out_err_o <= req_i && x_err;
         if (req_i) begin
            out_barrier_o <= x_bar;
            out_addr_o    <= x_addr;
         end
      end
   end
endmodule

// File: rtl/dwx_xlate_chk.sv
`timescale 1ns/1ps
module dwx_xlate_chk #(
   parameter int PORT_W     = 1,
   parameter bit STRICT_D64 = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_i,
   input logic [PORT_W-1:0] req_port_i,
   input logic [63:0]       req_addr_i,
   input logic              out_vld_o,
   input logic              out_err_o,
   input logic              out_barrier_o,
   input logic [63:0]       out_addr_o
);
   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R2
   resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_vld_o && out_err_o));

   // R2
   resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(req_i)) |-> (out_vld_o || out_err_o));

   // R2
   no_idle_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(req_i)) |-> (!out_vld_o && !out_err_o));

   // R3
   d64_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(req_i && req_addr_i[63]) && out_vld_o) |->
      (out_addr_o == {10'b0, $past(req_addr_i[53:0])} &&
       out_barrier_o == $past(req_addr_i[62])));

   // R8 R9
   no_barrier_40_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(req_i && req_addr_i[63:40] == '0 && req_addr_i[39:38] != 2'b00))
      |-> !out_barrier_o);

   // R11
   outside_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(req_i && !req_addr_i[63] && req_addr_i[62:40] != '0))
      |-> out_err_o);

   generate
      if (STRICT_D64) begin : g_rsv
         // R4
         d64_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && $past(req_i && req_addr_i[63] && req_addr_i[61:54] != '0))
            |-> out_err_o);
      end
   endgenerate

   logic unused_port;
   assign unused_port = ^req_port_i;
endmodule

bind dwx_xlate dwx_xlate_chk #(
   .PORT_W    (PORT_W),
   .STRICT_D64(STRICT_D64)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_i        (req_i),
   .req_port_i   (req_port_i),
   .req_addr_i   (req_addr_i),
   .out_vld_o    (out_vld_o),
   .out_err_o    (out_err_o),
   .out_barrier_o(out_barrier_o),
   .out_addr_o   (out_addr_o)
);

// File: tb/dwx_xlate_tb.sv
`timescale 1ns/1ps
module dwx_xlate_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_i = 1'b0;
   logic [0:0]  req_port_i = '0;
   logic [63:0] req_addr_i = '0;
   logic        cfg_we_i = 1'b0;
   logic [1:0]  cfg_tgt_i = '0;
   logic [6:0]  cfg_idx_i = '0;
   logic [63:0] cfg_data_i = '0;
   logic        out_vld_o, out_err_o, out_barrier_o;
   logic [63:0] out_addr_o;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   dwx_xlate u_dut (.*);

   // ---------------- reference model ----------------
   logic [63:0] m_shr [128];
   logic [63:0] m_m40 [64];
   logic [63:0] m_dir [2];   // upper part already shifted into place
   int          m_sh;
   bit          e_vld, e_err, e_bar;
   logic [63:0] e_addr;
   string       e_tag;

   task automatic model_reset();
      for (int i = 0; i < 128; i++) m_shr[i] = '0;
      for (int i = 0; i < 64; i++)  m_m40[i] = '0;
      m_dir[0] = '0; m_dir[1] = '0;
      m_sh = 18;
      e_vld = 0; e_err = 0; e_bar = 0; e_addr = '0; e_tag = "R1";
   endtask

   function automatic logic [63:0] page_lookup(input logic [63:0] ent, input logic [63:0] psz,
                                               input logic [63:0] off, output bit bad);
      logic [63:0] base;
      bad  = (ent[63] == 1'b0);
      base = ent & 64'h7FFF_FFFF_FFFF_FFFF;
      base = base - (base % psz);
      return base + (off % psz);
   endfunction

   task automatic model_step(input logic [63:0] a, input int port);
      bit err = 0, bar = 0;
      logic [63:0] sa = '0;
      logic [63:0] idx;
      if (a >= 64'h8000_0000_0000_0000) begin
         e_tag = "R3";
         if (((a >> 54) % 256) != 0) begin err = 1; e_tag = "R4"; end
         sa  = a % (64'd1 << 54);
         bar = a[62];
      end else if (a >= 64'h8000_0000 && a <= 64'hFFFF_FFFF) begin
         e_tag = "R5";
         if (m_dir[port] == 0) begin err = 1; e_tag = "R6"; end
         sa  = m_dir[port] + (a % (64'd1 << 30));
         bar = a[30];
      end else if (a <= 64'h7FFF_FFFF) begin
         e_tag = "R7";
         idx = (a % (64'd1 << 30)) / (64'd1 << m_sh);
         bar = a[30];
         if (idx >= 64) begin err = 1; e_tag = "R11"; end
         else begin
            sa = page_lookup(m_shr[64 + idx], 64'd1 << m_sh, a % (64'd1 << 30), err);
            if (err) e_tag = "R10";
         end
      end else if (a >= 64'h40_0000_0000 && a <= 64'h7F_FFFF_FFFF) begin
         e_tag = "R8";
         idx = (a - 64'h40_0000_0000) / (64'd1 << 26);
         if (idx >= 64) begin err = 1; e_tag = "R11"; end
         else begin
            sa = page_lookup(m_m40[idx], 64'd1 << 26, a, err);
            if (err) e_tag = "R10";
         end
      end else if (a >= 64'h80_0000_0000 && a <= 64'hFF_FFFF_FFFF) begin
         e_tag = "R9";
         idx = (a - 64'h80_0000_0000) / (64'd1 << 34) + 32 * port;
         sa  = page_lookup(m_shr[idx], 64'd1 << 34, a, err);
         if (err) e_tag = "R10";
      end else begin
         err = 1; e_tag = "R11";
      end
      e_vld = !err;
      e_err = err;
      e_bar = err ? 1'b0 : bar;
      e_addr = err ? 64'd0 : sa;
   endtask

   always @(posedge clk) begin
      if (rst_n) begin
         if (req_i) begin
            model_step(req_addr_i, int'(req_port_i));
            if (cfg_we_i) e_tag = {e_tag, "/R12"};
         end else begin
            e_vld = 0; e_err = 0; e_tag = "R2";
         end
         // writes land after the lookup of the same cycle (R12)
         if (cfg_we_i) begin
            case (cfg_tgt_i)
               2'd0: m_shr[cfg_idx_i] = cfg_data_i;
               2'd1: if (cfg_idx_i < 64) m_m40[cfg_idx_i] = cfg_data_i;
               2'd2: if (cfg_idx_i < 2) m_dir[cfg_idx_i] = cfg_data_i - (cfg_data_i % (64'd1 << 30));
               default: if (cfg_data_i[5:0] >= 12 && cfg_data_i[5:0] <= 30) m_sh = int'(cfg_data_i[5:0]);
            endcase
         end
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (out_vld_o !== e_vld || out_err_o !== e_err ||
             out_barrier_o !== e_bar || out_addr_o !== e_addr) begin
            failures++;
            $display("FAIL %s: got vld=%0b err=%0b bar=%0b addr=%h, expected vld=%0b err=%0b bar=%0b addr=%h",
                     e_tag, out_vld_o, out_err_o, out_barrier_o, out_addr_o,
                     e_vld, e_err, e_bar, e_addr);
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic rq(input logic [63:0] a, input bit p);
      @(negedge clk); #1;
      req_i = 1'b1; req_addr_i = a; req_port_i = p; cfg_we_i = 1'b0;
   endtask

   task automatic wr(input logic [1:0] t, input logic [6:0] ix, input logic [63:0] d);
      @(negedge clk); #1;
      req_i = 1'b0; cfg_we_i = 1'b1; cfg_tgt_i = t; cfg_idx_i = ix; cfg_data_i = d;
   endtask

   task automatic idle();
      @(negedge clk); #1;
      req_i = 1'b0; cfg_we_i = 1'b0;
   endtask

   task automatic direct_check(input string tag, input bit v, input bit e);
      @(negedge clk);
      checks++;
      if (out_vld_o !== v || out_err_o !== e) begin
         failures++;
         $display("FAIL %s: got vld=%0b err=%0b, expected vld=%0b err=%0b",
                  tag, out_vld_o, out_err_o, v, e);
      end
      #1; req_i = 1'b0; cfg_we_i = 1'b0;
   endtask

   initial begin
      #1_000_000;
      failures++;
      $display("FAIL watchdog: got no end of run, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      // R1: outputs low while reset is held
      @(negedge clk);
      checks++;
      if (out_vld_o !== 1'b0 || out_err_o !== 1'b0 || out_barrier_o !== 1'b0 || out_addr_o !== 64'd0) begin
         failures++;
         $display("FAIL R1: got vld=%0b err=%0b addr=%h, expected all zero",
                  out_vld_o, out_err_o, out_addr_o);
      end
      rst_n = 1'b1;
      idle(); idle();

      // R1: unconfigured state rejects table and direct lookups
      rq(64'h0000_1000, 1'b0);        direct_check("R1", 0, 1);
      rq(64'h40_0000_0000, 1'b0);     direct_check("R1", 0, 1);
      rq(64'h8000_0000, 1'b1);        direct_check("R1", 0, 1);

      // R3 / R4: 64-bit direct
      rq(64'h8000_0000_0000_1000, 1'b0);
      rq(64'hC03F_FFFF_FFFF_FFFF, 1'b1);
      rq(64'hA000_0000_0000_0000, 1'b0);
      rq(64'h8040_0000_0000_0000, 1'b0);
      rq(64'h8000_0000_0000_0000, 1'b0);
      idle();

      // R5 / R6: 32-bit direct
      wr(2'd2, 7'd0, 64'h0000_0012_4000_0000);
      rq(64'h8000_0010, 1'b0);
      rq(64'hC000_0010, 1'b1);        // port 1 still zero: R6
      wr(2'd2, 7'd1, 64'hFFFF_FFFF_C000_0000);
      rq(64'hFFFF_FFFF, 1'b1);
      rq(64'hBFFF_FFFF, 1'b0);
      idle();

      // R7 / R10 / R11: 32-bit mapped at reset page shift
      wr(2'd0, 7'd64, 64'h8000_0001_2340_0000);
      wr(2'd0, 7'd65, 64'h8000_00AB_CDEF_FFFF);
      wr(2'd0, 7'd66, 64'h0000_0005_0000_0000);  // not valid
      rq(64'h0000_1234, 1'b0);
      rq(64'h4000_1234, 1'b1);
      rq(64'h0004_0007, 1'b0);
      rq(64'h0008_0000, 1'b0);
      rq(64'h0100_0000, 1'b0);        // index 64: beyond table
      rq(64'h7FFF_FFFF, 1'b0);
      // R12: write to entry 66 in the same cycle as a lookup of it
      @(negedge clk); #1;
      req_i = 1'b1; req_addr_i = 64'h0008_0010; req_port_i = 1'b0;
      cfg_we_i = 1'b1; cfg_tgt_i = 2'd0; cfg_idx_i = 7'd66; cfg_data_i = 64'h8000_0033_0000_0000;
      rq(64'h0008_0010, 1'b0);
      // R12: page shift 20, then an out-of-range shift that must be ignored
      wr(2'd3, 7'd0, 64'd20);
      rq(64'h0010_0456, 1'b0);
      wr(2'd3, 7'd0, 64'd40);
      rq(64'h0010_0456, 1'b0);
      rq(64'h0020_0001, 1'b0);
      wr(2'd3, 7'd0, 64'd18);
      idle();

      // R8: 40-bit mapped
      wr(2'd1, 7'd0, 64'h8000_0100_0000_0000);
      wr(2'd1, 7'd5, 64'h8000_0200_0C00_0000);
      rq(64'h40_0000_0100, 1'b0);
      rq(64'h40_1400_0008, 1'b1);
      rq(64'h40_FC00_0000, 1'b0);     // index 63 invalid: R10
      rq(64'h41_0000_0000, 1'b0);     // index 64: R11
      rq(64'h7F_FFFF_FFFF, 1'b0);
      idle();

      // R9: super-page partitions per port
      wr(2'd0, 7'd0,  64'h8000_1000_0000_0000);
      wr(2'd0, 7'd33, 64'h8000_2004_0000_0000);
      rq(64'h80_0000_0055, 1'b0);
      rq(64'h84_0000_0000, 1'b1);
      rq(64'h84_0000_0000, 1'b0);     // port 0 index 1 invalid
      rq(64'h80_0000_0055, 1'b1);     // port 1 index 32 invalid
      rq(64'hFF_FFFF_FFFF, 1'b1);
      idle();

      // R11: gaps between windows
      rq(64'h1_0000_0000, 1'b0);
      rq(64'h3F_FFFF_FFFF, 1'b1);
      rq(64'h100_0000_0000, 1'b0);
      rq(64'h7FFF_FFFF_FFFF_FFFF, 1'b0);
      idle(); idle();

      // mixed traffic
      for (int n = 0; n < 400; n++) begin
         int w;
         logic [63:0] a;
         w = int'($urandom_range(0, 6));
         a = {$urandom, $urandom};
         case (w)
            0: a = {2'b10, 8'h00, a[53:0]} | (($urandom_range(0, 7) == 0) ? 64'h0200_0000_0000_0000 : 64'd0);
            1: a = {32'd0, 1'b1, a[30:0]};
            2: a = {32'd0, 1'b0, a[30:24], 6'd0, a[17:0]};
            3: a = {24'd0, 2'b01, 6'd0, a[31:0]};
            4: a = {24'd0, 1'b1, a[38:0]};
            5: a = {40'd0, a[23:0]};
            default: ;
         endcase
         if ($urandom_range(0, 4) == 0) begin
            logic [6:0] ix;
            ix = 7'($urandom_range(0, 127));
            @(negedge clk); #1;
            cfg_we_i = 1'b1; cfg_tgt_i = 2'($urandom_range(0, 2));
            cfg_idx_i = ix; cfg_data_i = {$urandom, $urandom};
            req_i = 1'b1; req_addr_i = a; req_port_i = 1'($urandom_range(0, 1));
         end else begin
            rq(a, 1'($urandom_range(0, 1)));
         end
      end
      idle(); idle(); idle();

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule